// File: doc/BRIEF.md
# Device Event Log Controller

This block holds a small set of event queues for a memory-expansion device, one queue for each log type. An internal event source pushes fixed-size records into a chosen queue. The block gives each accepted record a per-log handle and stamps it with the current time. When a queue is full the record is dropped, and the block keeps a count of the drops together with the time of the first and the last one.

The host side sends one command at a time. A read command streams the oldest records of a log without removing them and then returns a summary. A clear command removes records from the head of a log. It does this only after every handle supplied with the command has matched the record at the same position. A per-log status vector shows which logs hold records. A one-cycle interrupt request fires whenever a log that was empty receives its first record.

Top module: `evlog_ctrl`

## Requirements
- R1: An accepted insert is stored at the tail of its log. The block first overwrites two fields of the record: the handle goes into the 16-bit little-endian field at byte 20 (bits [175:160]), and `time_now` goes into the 64-bit little-endian field at byte 24 (bits [255:192]). All other bits are kept unchanged.
- R2: Each log has its own HANDLE_W-bit handle counter. It is 1 after reset and advances by one on every accepted insert. On wraparound it skips 0, so the value after the all-ones handle is 1.
- R3: Bit k of `status` is 1 exactly while log k holds at least one record. `irq_req` is high for one cycle after an accepted insert that takes its log from 0 records to 1, and is low otherwise.
- R4: An insert into a log that already holds DEPTH records is dropped and raises no interrupt. The drop increments that log's overflow count and loads the last-overflow time with `time_now`. It loads the first-overflow time only when the count was zero before the drop.
- R5: A read streams min(`cmd_num`, occupancy) records on `rec_valid`/`rec_data`, oldest first, one per cycle. It then raises `rsp_valid` with `rsp_count` equal to that number. The log is left unchanged.
- R6: A read response sets `rsp_flags[1]` when the log is non-empty and `rsp_flags[0]` when its overflow count is non-zero. It also reports the overflow count, the first-overflow time and the last-overflow time.
- R7: A clear checks handle slot i of `cmd_handles` (bits [16i+15:16i]) against the record at position i from the head, for i below both `cmd_num` and the occupancy. A zero handle or a mismatch in any checked slot gives `rsp_bad`=1 and removes nothing.
- R8: A clear that passes the check removes min(`cmd_num`, occupancy) records from the head and reports that number in `rsp_count`. If it removes any record, the overflow count and both overflow times of that log return to zero.
- R9: When `cmd_num` is larger than the occupancy, only the records present are checked and removed. Handle slots beyond them are ignored, and the clear succeeds.
- R10: A read or clear whose `cmd_log` is NUM_LOGS or above returns `rsp_bad`=1. An insert whose `ins_log` is NUM_LOGS or above is accepted but changes no log and raises no interrupt.
- R11: After reset all logs are empty and both ready outputs are high. `cmd_ready` is low while a read is streaming. `ins_ready` is low while a command is pending or in progress, so a command always wins over an insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current device time |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted when high together with ins_valid |
| ins_log | input | SEL_W | Target log of the insert |
| ins_rec | input | REC_BYTES*8 | Record to insert |
| cmd_valid | input | 1 | Host command request |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_clear | input | 1 | 0 = read, 1 = clear |
| cmd_log | input | SEL_W | Target log of the command |
| cmd_num | input | $clog2(DEPTH+1) | Read: maximum records; clear: number of handles |
| cmd_handles | input | DEPTH*16 | Handles for a clear, slot i at bits [16i+15:16i] |
| rec_valid | output | 1 | A streamed read record is present |
| rec_data | output | REC_BYTES*8 | Streamed read record |
| rsp_valid | output | 1 | One-cycle command response |
| rsp_bad | output | 1 | Invalid-input result |
| rsp_flags | output | 2 | Bit 1 more records, bit 0 overflow (read only) |
| rsp_count | output | $clog2(DEPTH+1) | Records returned or removed |
| rsp_ovf_cnt | output | 16 | Overflow count (read only) |
| rsp_ovf_first | output | 64 | First overflow time (read only) |
| rsp_ovf_last | output | 64 | Last overflow time (read only) |
| status | output | NUM_LOGS | Per-log non-empty bits |
| irq_req | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with NUM_LOGS=4, DEPTH=8, HANDLE_W=4 and REC_BYTES=32. A 4-bit handle counter wraps after fifteen inserts, so the skip over zero can be checked in a few hundred cycles. A 32-byte record is just large enough to hold both overwritten fields. Eight-deep logs let a single log be filled to the overflow point and then drained. Selector values 4 through 255 are outside the supported logs and are used to check rejection.

// File: rtl/evlog_ctrl.sv
module evlog_ctrl #(
  parameter int NUM_LOGS  = 4,
  parameter int DEPTH     = 8,
  parameter int HANDLE_W  = 16,
  parameter int REC_BYTES = 128,
  parameter int SEL_W     = 8,
  localparam int REC_W    = REC_BYTES * 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [63:0]           time_now,
  input  logic                  ins_valid,
  output logic                  ins_ready,
  input  logic [SEL_W-1:0]      ins_log,
  input  logic [REC_W-1:0]      ins_rec,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_clear,
  input  logic [SEL_W-1:0]      cmd_log,
  input  logic [CNT_W-1:0]      cmd_num,
  input  logic [DEPTH*16-1:0]   cmd_handles,
  output logic                  rec_valid,
  output logic [REC_W-1:0]      rec_data,
  output logic                  rsp_valid,
  output logic                  rsp_bad,
  output logic [1:0]            rsp_flags,
  output logic [CNT_W-1:0]      rsp_count,
  output logic [15:0]           rsp_ovf_cnt,
  output logic [63:0]           rsp_ovf_first,
  output logic [63:0]           rsp_ovf_last,
  output logic [NUM_LOGS-1:0]   status,
  output logic                  irq_req
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LOG_W = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1;
  localparam int HPOS  = 160;
  localparam int TPOS  = 192;
  localparam logic [SEL_W-1:0] NLOG = SEL_W'(NUM_LOGS);

  logic [REC_W-1:0]    mem [NUM_LOGS][DEPTH];
  logic [PTR_W-1:0]    head [NUM_LOGS];
  logic [PTR_W-1:0]    tail [NUM_LOGS];
  logic [CNT_W-1:0]    occ [NUM_LOGS];
  logic [HANDLE_W-1:0] nxt_h [NUM_LOGS];
  logic [15:0]         ovf_cnt [NUM_LOGS];
  logic [63:0]         ovf_first [NUM_LOGS];
  logic [63:0]         ovf_last [NUM_LOGS];

  logic             busy;
  logic [LOG_W-1:0] rd_log;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] rd_left;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire [LOG_W-1:0] il = ins_log[LOG_W-1:0];
  wire [LOG_W-1:0] cl = cmd_log[LOG_W-1:0];

  assign cmd_ready = !busy;
  assign ins_ready = !busy && !cmd_valid;
  assign rec_valid = busy;
  assign rec_data  = mem[rd_log][rd_ptr];

  wire ins_ok  = ins_valid && ins_ready && (ins_log < NLOG);
  wire ins_fit = occ[il] != CNT_W'(DEPTH);
  wire cmd_ok  = cmd_log < NLOG;

  wire [CNT_W-1:0] c_occ  = occ[cl];
  wire [PTR_W-1:0] c_head = head[cl];
  wire [CNT_W-1:0] n_take = (cmd_num < c_occ) ? cmd_num : c_occ;

  logic [REC_W-1:0]    ins_w;
  logic [HANDLE_W-1:0] h_inc, h_next;
  logic [CNT_W:0]      adv;
  logic                hs_ok;

  always_comb begin
    ins_w = ins_rec;
    ins_w[HPOS +: 16] = 16'(nxt_h[il]);
    ins_w[TPOS +: 64] = time_now;
    h_inc  = nxt_h[il] + 1'b1;
    h_next = (h_inc == '0) ? HANDLE_W'(1) : h_inc;
    adv = (CNT_W+1)'(c_head) + (CNT_W+1)'(n_take);
    if (adv >= (CNT_W+1)'(DEPTH)) adv = adv - (CNT_W+1)'(DEPTH);
    for (int g = 0; g < NUM_LOGS; g++) status[g] = occ[g] != '0;
  end

  always_comb begin
    logic [PTR_W:0] s;
    logic [15:0]    hv;
    hs_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      s = (PTR_W+1)'(c_head) + (PTR_W+1)'(i);
      if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
      hv = cmd_handles[i*16 +: 16];
      if (CNT_W'(i) < cmd_num && CNT_W'(i) < c_occ &&
          (hv == 16'h0 || hv != mem[cl][s[PTR_W-1:0]][HPOS +: 16]))
        hs_ok = 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (ins_ok && ins_fit) mem[il][tail[il]] <= ins_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_LOGS; g++) begin
        head[g] <= '0; tail[g] <= '0; occ[g] <= '0;
        nxt_h[g] <= HANDLE_W'(1);
        ovf_cnt[g] <= '0; ovf_first[g] <= '0; ovf_last[g] <= '0;
      end
      busy <= 1'b0; rd_log <= '0; rd_ptr <= '0; rd_left <= '0;
      rsp_valid <= 1'b0; rsp_bad <= 1'b0; rsp_flags <= '0; rsp_count <= '0;
      rsp_ovf_cnt <= '0; rsp_ovf_first <= '0; rsp_ovf_last <= '0;
      irq_req <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      irq_req   <= 1'b0;
      if (busy) begin
        rd_ptr  <= step(rd_ptr);
        rd_left <= rd_left - 1'b1;
        if (rd_left == CNT_W'(1)) begin
          busy <= 1'b0;
          rsp_valid <= 1'b1;
        end
      end else if (cmd_valid) begin
        rsp_bad <= 1'b0; rsp_flags <= '0; rsp_count <= '0;
        rsp_ovf_cnt <= '0; rsp_ovf_first <= '0; rsp_ovf_last <= '0;
        if (!cmd_ok || (cmd_clear && !hs_ok)) begin
          rsp_bad <= 1'b1;
          rsp_valid <= 1'b1;
        end else if (!cmd_clear) begin
          rsp_count <= n_take;
          rsp_flags <= {c_occ != '0, ovf_cnt[cl] != '0};
          rsp_ovf_cnt <= ovf_cnt[cl];
          rsp_ovf_first <= ovf_first[cl];
          rsp_ovf_last <= ovf_last[cl];
          if (n_take != '0) begin
            busy <= 1'b1; rd_log <= cl; rd_ptr <= c_head; rd_left <= n_take;
          end else rsp_valid <= 1'b1;
        end else begin
          head[cl] <= adv[PTR_W-1:0];
          occ[cl] <= c_occ - n_take;
          rsp_count <= n_take;
          rsp_valid <= 1'b1;
          if (n_take != '0) begin
            ovf_cnt[cl] <= '0; ovf_first[cl] <= '0; ovf_last[cl] <= '0;
          end
        end
      end else if (ins_ok) begin
        if (!ins_fit) begin
          ovf_cnt[il] <= ovf_cnt[il] + 1'b1;
          if (ovf_cnt[il] == '0) ovf_first[il] <= time_now;
          ovf_last[il] <= time_now;
        end else begin
          tail[il] <= step(tail[il]);
          occ[il] <= occ[il] + 1'b1;
          nxt_h[il] <= h_next;
          if (occ[il] == '0) irq_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evlog_ctrl_chk.sv
module evlog_ctrl_chk #(
  parameter int NUM_LOGS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ins_valid,
  input logic                ins_ready,
  input logic                rec_valid,
  input logic                rsp_valid,
  input logic                rsp_bad,
  input logic [NUM_LOGS-1:0] status,
  input logic                irq_req
);
  assert_irq_from_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(ins_valid && ins_ready));

  assert_status_fall_on_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~status & $past(status))) |-> (rsp_valid && !rsp_bad));

  assert_stream_then_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (rec_valid || rsp_valid));

  assert_rsp_after_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rec_valid);

  assert_bad_keeps_logs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bad) |-> $stable(status));

  assert_insert_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !ins_ready);
endmodule

bind evlog_ctrl evlog_ctrl_chk #(.NUM_LOGS(NUM_LOGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .rec_valid(rec_valid), .rsp_valid(rsp_valid), .rsp_bad(rsp_bad),
  .status(status), .irq_req(irq_req));

// File: tb/evlog_ctrl_test.sv
`timescale 1ns/1ps
module evlog_ctrl_test;
  localparam int NL = 4, DP = 8, HW = 4, RB = 32;
  localparam int RW = RB * 8, CW = $clog2(DP + 1);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [63:0] time_now = 0;
  logic ins_valid = 0, cmd_valid = 0, cmd_clear = 0;
  logic [7:0] ins_log = 0, cmd_log = 0;
  logic [RW-1:0] ins_rec = 0;
  logic [CW-1:0] cmd_num = 0;
  logic [DP*16-1:0] cmd_handles = 0;
  logic ins_ready, cmd_ready, rec_valid, rsp_valid, rsp_bad, irq_req;
  logic [RW-1:0] rec_data;
  logic [1:0] rsp_flags;
  logic [CW-1:0] rsp_count;
  logic [15:0] rsp_ovf_cnt;
  logic [63:0] rsp_ovf_first, rsp_ovf_last;
  logic [NL-1:0] status;

  evlog_ctrl #(.NUM_LOGS(NL), .DEPTH(DP), .HANDLE_W(HW), .REC_BYTES(RB), .SEL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_log(ins_log), .ins_rec(ins_rec),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_clear(cmd_clear), .cmd_log(cmd_log),
    .cmd_num(cmd_num), .cmd_handles(cmd_handles),
    .rec_valid(rec_valid), .rec_data(rec_data),
    .rsp_valid(rsp_valid), .rsp_bad(rsp_bad), .rsp_flags(rsp_flags), .rsp_count(rsp_count),
    .rsp_ovf_cnt(rsp_ovf_cnt), .rsp_ovf_first(rsp_ovf_first), .rsp_ovf_last(rsp_ovf_last),
    .status(status), .irq_req(irq_req));

  int total = 0, bad = 0;
  bit done = 0;
  logic [RW-1:0] got [DP];
  int got_n;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] pat(input logic [15:0] t);
    return {8{t, 16'hC0DE}};
  endfunction

  function automatic logic [RW-1:0] stored(input logic [15:0] t, input logic [15:0] h);
    logic [RW-1:0] r = pat(t);
    r[175:160] = h;
    r[255:192] = 64'(t);
    return r;
  endfunction

  task automatic do_ins(input logic [7:0] lg, input logic [15:0] t);
    @(negedge clk);
    ins_valid = 1; ins_log = lg; ins_rec = pat(t); time_now = 64'(t);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic do_cmd(input bit clr, input logic [7:0] lg, input int n);
    @(negedge clk);
    cmd_valid = 1; cmd_clear = clr; cmd_log = lg; cmd_num = CW'(n);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    got_n = 0;
    while (1) begin
      if (rec_valid && got_n < DP) begin got[got_n] = rec_data; got_n++; end
      if (rsp_valid) break;
      @(negedge clk);
    end
  endtask

  // {log[7:0], time[15:0], exp_irq, exp_status[3:0]}
  localparam logic [28:0] INS_TAB [5] = '{
    {8'd0, 16'd100, 1'b1, 4'b0001},
    {8'd0, 16'd101, 1'b0, 4'b0001},
    {8'd2, 16'd102, 1'b1, 4'b0101},
    {8'd5, 16'd103, 1'b0, 4'b0101},
    {8'd0, 16'd104, 1'b0, 4'b0101}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset status", status, 0);
    chk("R11 reset ins_ready", ins_ready, 1);
    chk("R11 reset cmd_ready", cmd_ready, 1);
    chk("R3 reset irq", irq_req, 0);
    rst_n = 1;

    for (int k = 0; k < 5; k++) begin
      do_ins(INS_TAB[k][28:21], INS_TAB[k][20:5]);
      chk($sformatf("R3 irq step %0d", k), irq_req, INS_TAB[k][4]);
      chk($sformatf("R3 R10 status step %0d", k), status, INS_TAB[k][3:0]);
    end

    do_cmd(0, 0, 2);
    chk("R5 read count", rsp_count, 2);
    chk("R5 streamed", got_n, 2);
    chk("R1 R2 rec0", got[0] == stored(100, 1), 1);
    chk("R1 R2 rec1", got[1] == stored(101, 2), 1);
    chk("R6 flags", rsp_flags, 2'b10);
    do_cmd(0, 0, 8);
    chk("R5 non-destructive count", rsp_count, 3);
    chk("R1 third handle", got[2][175:160], 3);
    chk("R1 third time", got[2][255:192], 104);
    do_cmd(0, 0, 0);
    chk("R6 more flag with max 0", rsp_flags, 2'b10);
    chk("R5 max 0 count", rsp_count, 0);
    do_cmd(0, 3, 4);
    chk("R6 empty flags", rsp_flags, 2'b00);
    do_cmd(0, 4, 4);
    chk("R10 read bad log", rsp_bad, 1);

    cmd_handles = 0; cmd_handles[15:0] = 1; cmd_handles[31:16] = 3;
    do_cmd(1, 0, 2);
    chk("R7 mismatch bad", rsp_bad, 1);
    do_cmd(0, 0, 8);
    chk("R7 nothing removed", rsp_count, 3);
    cmd_handles = 0; cmd_handles[31:16] = 2;
    do_cmd(1, 0, 2);
    chk("R7 zero handle bad", rsp_bad, 1);
    cmd_handles = 0; cmd_handles[15:0] = 1; cmd_handles[31:16] = 2;
    do_cmd(1, 0, 2);
    chk("R8 clear ok", rsp_bad, 0);
    chk("R8 clear count", rsp_count, 2);
    do_cmd(0, 0, 8);
    chk("R8 remaining", rsp_count, 1);
    chk("R8 new head", got[0][175:160], 3);
    do_cmd(1, 9, 1);
    chk("R10 clear bad log", rsp_bad, 1);

    for (int k = 0; k < 8; k++) do_ins(1, 16'(200 + k));
    chk("R3 status full", status, 4'b0111);
    do_ins(1, 300);
    chk("R4 no irq on drop", irq_req, 0);
    do_ins(1, 301);
    do_cmd(0, 1, 8);
    chk("R4 count kept", rsp_count, 8);
    chk("R6 overflow flags", rsp_flags, 2'b11);
    chk("R4 ovf count", rsp_ovf_cnt, 2);
    chk("R4 first time", rsp_ovf_first, 300);
    chk("R4 last time", rsp_ovf_last, 301);
    chk("R5 oldest first", got[7] == stored(207, 8), 1);
    cmd_handles = 0; cmd_handles[15:0] = 1;
    do_cmd(1, 1, 1);
    do_cmd(0, 1, 8);
    chk("R8 ovf reset flags", rsp_flags, 2'b10);
    chk("R8 ovf reset count", rsp_ovf_cnt, 0);
    chk("R8 ovf reset times", rsp_ovf_first | rsp_ovf_last, 0);

    cmd_handles = 0;
    for (int i = 0; i < 7; i++) cmd_handles[i*16 +: 16] = 16'(i + 2);
    cmd_handles[127:112] = 16'hBEEF;
    do_cmd(1, 1, 9);
    chk("R9 early stop ok", rsp_bad, 0);
    chk("R9 early stop count", rsp_count, 7);
    chk("R9 R3 status cleared", status, 4'b0101);

    for (int k = 0; k < 16; k++) begin
      logic [15:0] eh;
      eh = (k < 15) ? 16'(k + 1) : 16'd1;
      do_ins(3, 16'(500 + k));
      chk($sformatf("R3 irq wrap %0d", k), irq_req, 1);
      do_cmd(0, 3, 1);
      chk($sformatf("R2 handle wrap %0d", k), got[0][175:160], eh);
      cmd_handles = 0; cmd_handles[15:0] = eh;
      do_cmd(1, 3, 1);
      chk($sformatf("R8 wrap clear %0d", k), rsp_count, 1);
    end

    @(negedge clk);
    cmd_valid = 1; cmd_clear = 0; cmd_log = 0; cmd_num = 1;
    ins_valid = 1; ins_log = 0; ins_rec = pat(900);
    #1;
    chk("R11 command blocks insert", ins_ready, 0);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; ins_valid = 0;
    repeat (3) @(negedge clk);
    do_cmd(0, 0, 8);
    chk("R11 insert not taken", rsp_count, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule